// File: doc/BRIEF.md
# Two-Lane Serial ADC Sample Deserializer

This block takes one converter channel whose output has been serialized onto two data lanes plus a frame marker line, and rebuilds parallel samples. Every sample takes one frame of eight bit slots on each lane. One lane carries the odd-numbered data bits and the other carries the even-numbered bits, both most significant first, and each lane ends the frame with a zero pad slot. All three lines arrive single-ended and already in the bit-clock domain. Bits are taken on both clock edges, so one frame lasts four bit-clock cycles.

The marker line is sampled like a data lane and must show four ones followed by four zeros in each frame. The block searches the eight possible bit alignments for that pattern. It declares lock after several consistent frames and drops lock after repeated mismatches. While locked it emits one strobe per frame, carrying the 14-bit two's-complement sample sign-extended to 16 bits. A pad-error flag comes with the strobe when either lane's pad slot held a one.

Top module: `adc2l_deser`

## Requirements
- R1: In a frame, the odd lane (`ln_odd`) carries D13, D11, D9, D7, D5, D3, D1 from the first slot to the seventh, and its eighth slot is the pad bit; these bits land at those positions of the rebuilt sample.
- R2: In the same frame, the even lane (`ln_even`) carries D12, D10, D8, D6, D4, D2, D0 from the first slot to the seventh, and its eighth slot is the pad bit.
- R3: `smp` is the rebuilt 14-bit sample in two's complement, with D13 as the sign bit copied into bits 15 and 14.
- R4: Each bit-clock cycle carries two slots: the earlier slot is sampled on the rising edge and the later slot on the following falling edge. The strobe for a frame rises on the second rising edge after the edge that captured that frame's final slot.
- R5: A frame is recognized when the marker line reads 1,1,1,1,0,0,0,0 over its eight slots, so the first slot (D13 and D12) is the first 1. `frm_lock` rises after 4 consecutive recognized frames, on the same edge as the strobe for the fourth of them; earlier frames produce no strobe.
- R6: `smp_vld` is a single-cycle strobe, is high only while `frm_lock` is high, and consecutive strobes are at least 4 cycles apart.
- R7: While locked, a single mismatching frame keeps lock and still yields a strobe with that frame's data. A second consecutive mismatch drops `frm_lock` and yields no strobe.
- R8: After lock is lost, the block realigns to the marker at any of the 8 bit positions, including a shift by an odd number of slots. It then needs 4 more recognized frames before it locks again.
- R9: `pad_err` is high together with a strobe when either lane's pad slot in that frame was 1. Pad bits in frames received while unlocked never raise it.
- R10: A synchronous active-high `rst` clears `frm_lock`, `smp_vld` and `pad_err`. Frames sent while `rst` is held never cause lock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bclk | input | 1 | Bit clock; both edges capture data |
| rst | input | 1 | Synchronous active-high reset |
| ln_odd | input | 1 | Serial lane with odd data bits and a pad slot |
| ln_even | input | 1 | Serial lane with even data bits and a pad slot |
| fmark | input | 1 | Frame marker line, high for the first half of each frame |
| smp | output | 16 | Sign-extended rebuilt sample |
| smp_vld | output | 1 | One-cycle strobe per locked frame |
| frm_lock | output | 1 | Frame alignment established |
| pad_err | output | 1 | A pad slot held 1 in the strobed frame |

## Verification
A frame's strobe, sample and pad flag are registered together on the second rising edge after the final slot is captured. The bench records the cycle number at which each frame's last slot is driven, and the cycle and values of every strobe seen on a falling edge. It then checks both the values and the two-cycle gap frame by frame. Lock gain needs four frames, one mismatch costs nothing, and a second drops lock. For these cases the checks index strobes relative to the start of each phase and count the falling edges of the lock flag, so a strobe still in flight from the previous phase is counted on purpose. Reset effects are sampled one falling edge after the reset edge.

// File: rtl/adc2l_deser.sv
module adc2l_deser #(
  parameter int DW     = 14,
  parameter int OW     = 16,
  parameter int LOCK_N = 4,
  parameter int LOSS_N = 2
) (
  input  logic          bclk,
  input  logic          rst,
  input  logic          ln_odd,
  input  logic          ln_even,
  input  logic          fmark,
  output logic [OW-1:0] smp,
  output logic          smp_vld,
  output logic          frm_lock,
  output logic          pad_err
);
  localparam int LB  = DW / 2 + 1;
  localparam int CPF = LB / 2;
  localparam int HW  = LB + 1;
  localparam int CW  = $clog2(CPF + 1);
  localparam int GW  = $clog2(LOCK_N + 1);
  localparam int BW  = $clog2(LOSS_N + 1);
  localparam logic [LB-1:0] PAT = {{(LB/2){1'b1}}, {(LB-LB/2){1'b0}}};

  logic [2:0]    r_q, f_q;
  logic [HW-1:0] ha, hb, hf;
  logic [CW-1:0] cnt;
  logic [GW-1:0] good;
  logic [BW-1:0] bad;
  logic          off;

  always_ff @(posedge bclk) r_q <= {ln_odd, ln_even, fmark};
  always_ff @(negedge bclk) f_q <= {ln_odd, ln_even, fmark};

  always_ff @(posedge bclk) begin
    ha <= {ha[HW-3:0], r_q[2], f_q[2]};
    hb <= {hb[HW-3:0], r_q[1], f_q[1]};
    hf <= {hf[HW-3:0], r_q[0], f_q[0]};
  end

  wire m0 = hf[LB-1:0] == PAT;
  wire m1 = hf[LB:1] == PAT;
  wire [LB-1:0] wa = off ? ha[LB:1] : ha[LB-1:0];
  wire [LB-1:0] wb = off ? hb[LB:1] : hb[LB-1:0];

  logic [DW-1:0] d;
  always_comb begin
    d = '0;
    for (int i = 0; i < LB - 1; i++) begin
      d[DW-1-2*i] = wa[LB-1-i];
      d[DW-2-2*i] = wb[LB-1-i];
    end
  end

  wire tracking = frm_lock | (good != '0);
  wire fend     = cnt == CW'(CPF - 1);
  wire hit      = tracking ? (off ? m1 : m0) : (m0 | m1);
  wire lock_n   = frm_lock ? !(fend && !hit && bad == BW'(LOSS_N - 1))
                           : (tracking && fend && hit && good == GW'(LOCK_N - 1));
  wire emit     = tracking && fend && lock_n;

  always_ff @(posedge bclk) begin
    if (rst) begin
      frm_lock <= 1'b0;
      smp_vld  <= 1'b0;
      pad_err  <= 1'b0;
      smp      <= '0;
      good     <= '0;
      bad      <= '0;
      cnt      <= '0;
      off      <= 1'b0;
    end else begin
      frm_lock <= lock_n;
      smp_vld  <= emit;
      pad_err  <= emit & (wa[0] | wb[0]);
      if (emit) smp <= {{(OW-DW){d[DW-1]}}, d};
      cnt <= fend ? '0 : cnt + 1'b1;
      if (!tracking) begin
        if (hit) begin
          cnt  <= '0;
          off  <= !m0;
          good <= GW'(1);
        end
      end else if (fend) begin
        if (hit) begin
          bad <= '0;
          if (!frm_lock && good != GW'(LOCK_N)) good <= good + 1'b1;
        end else if (frm_lock) begin
          if (bad == BW'(LOSS_N - 1)) begin
            good <= '0;
            bad  <= '0;
          end else begin
            bad <= bad + 1'b1;
          end
        end else begin
          good <= '0;
        end
      end
    end
  end
endmodule

// File: rtl/adc2l_deser_chk.sv
module adc2l_deser_chk #(
  parameter int DW = 14,
  parameter int OW = 16
) (
  input logic          bclk,
  input logic          rst,
  input logic [OW-1:0] smp,
  input logic          smp_vld,
  input logic          frm_lock,
  input logic          pad_err
);
  localparam int CPF = (DW / 2 + 1) / 2;
  logic [7:0] since;

  always_ff @(posedge bclk) begin
    if (rst) since <= 8'(CPF);
    else if (smp_vld) since <= 8'd1;
    else if (since < 8'(CPF)) since <= since + 8'd1;
  end

  AST_VLD_SPACING: assert property (@(posedge bclk) disable iff (rst) smp_vld |-> since >= 8'(CPF)); // R6
  AST_VLD_LOCKED: assert property (@(posedge bclk) disable iff (rst) smp_vld |-> frm_lock); // R6
  AST_LOCK_FIRST_VLD: assert property (@(posedge bclk) disable iff (rst) $rose(frm_lock) |-> smp_vld); // R5
  AST_LOSS_QUIET: assert property (@(posedge bclk) disable iff (rst) $fell(frm_lock) |-> !smp_vld); // R7
  AST_ERR_WITH_VLD: assert property (@(posedge bclk) disable iff (rst) pad_err |-> smp_vld); // R9
  AST_SIGN_EXT: assert property (@(posedge bclk) disable iff (rst)
    smp_vld |-> ((&smp[OW-1:DW-1]) || !(|smp[OW-1:DW-1]))); // R3
endmodule

bind adc2l_deser adc2l_deser_chk #(.DW(DW), .OW(OW)) u_chk (
  .bclk(bclk), .rst(rst), .smp(smp), .smp_vld(smp_vld),
  .frm_lock(frm_lock), .pad_err(pad_err)
);

// File: tb/adc2l_deser_bench.sv
module adc2l_deser_bench;
  logic bclk = 0, rst = 1, ln_odd = 0, ln_even = 0, fmark = 0;
  logic [15:0] smp;
  logic smp_vld, frm_lock, pad_err;

  adc2l_deser u_adc2l_deser (
    .bclk(bclk), .rst(rst), .ln_odd(ln_odd), .ln_even(ln_even), .fmark(fmark),
    .smp(smp), .smp_vld(smp_vld), .frm_lock(frm_lock), .pad_err(pad_err)
  );

  always #10 bclk = ~bclk;

  // {pad_odd, pad_even, data14}
  localparam logic [15:0] VEC [12] = '{
    16'h0000, 16'h1FFF, 16'h2000, 16'h3FFF, 16'hAAAA, 16'h5555,
    16'hC001, 16'h3FFE, 16'h0F0F, 16'hB0C3, 16'h2001, 16'h1000
  };

  int checks = 0, errors = 0, cyc = 0;
  int nv = 0, nf = 0, nerr = 0, nfall = 0;
  logic [15:0] gs [64];
  logic        ge [64];
  int          gc [64];
  int          fc [64];
  logic        lk_d = 0;
  bit          ph = 0;

  always @(posedge bclk) cyc++;

  always @(negedge bclk) begin
    if (smp_vld && nv < 64) begin
      gs[nv] = smp; ge[nv] = pad_err; gc[nv] = cyc; nv++;
    end
    if (pad_err) nerr++;
    if (lk_d && !frm_lock) nfall++;
    lk_d = frm_lock;
  end

  function automatic logic [15:0] sx(input logic [13:0] d);
    return {{2{d[13]}}, d};
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic send_bit(input logic a, input logic b, input logic f);
    if (!ph) begin @(negedge bclk); #2; end
    else begin @(posedge bclk); #2; end
    ln_odd = a; ln_even = b; fmark = f;
    ph = !ph;
  endtask

  task automatic send_frame(input logic [13:0] d, input logic pa, input logic pb, input bit good);
    for (int i = 0; i < 8; i++) begin
      if (i < 7) send_bit(d[13-2*i], d[12-2*i], good && i < 4);
      else       send_bit(pa, pb, 1'b0);
    end
    if (nf < 64) begin fc[nf] = cyc; nf++; end
  endtask

  initial begin
    repeat (200000) @(posedge bclk);
    checks++; errors++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int b, f0, e, n0;
    // R10: frames under reset never lock
    for (int k = 0; k < 5; k++) send_frame(14'h0123, 1'b0, 1'b0, 1'b1);
    send_frame(14'h0, 1'b0, 1'b0, 1'b0);
    @(negedge bclk); #1;
    chk(frm_lock == 0 && smp_vld == 0 && pad_err == 0, "R10 reset state", {frm_lock, smp_vld, pad_err}, 0);
    chk(nv == 0, "R10 no strobe under reset", nv, 0);
    rst = 0;

    // Table walk: R1 R2 R3 R4 R5 R9
    nf = 0; nv = 0; nerr = 0;
    for (int k = 0; k < 3; k++) send_frame(14'h1234, 1'b1, 1'b1, 1'b1);
    for (int k = 0; k < 12; k++) send_frame(VEC[k][13:0], VEC[k][15], VEC[k][14], 1'b1);
    send_frame(14'h0, 1'b0, 1'b0, 1'b1);
    send_frame(14'h0, 1'b0, 1'b0, 1'b1);
    chk(gc[0] - fc[3] == 2, "R5 first strobe on fourth frame", gc[0] - fc[3], 2);
    for (int k = 0; k < 12; k++) begin
      chk(gs[k] == sx(VEC[k][13:0]), "R1 R2 R3 sample", gs[k], sx(VEC[k][13:0]));
      chk(ge[k] == (VEC[k][15] | VEC[k][14]), "R9 pad flag", ge[k], VEC[k][15] | VEC[k][14]);
      chk(gc[k] - fc[k+3] == 2, "R4 latency", gc[k] - fc[k+3], 2);
    end
    chk(nerr == 4, "R9 unlocked pads ignored", nerr, 4);
    chk(frm_lock == 1, "R5 lock held", frm_lock, 1);
    chk(gc[1] - gc[0] == 4, "R6 strobe spacing", gc[1] - gc[0], 4);

    // Loss of lock: R7
    b = nv + 1; f0 = nfall;
    send_frame(14'h0ABC, 1'b0, 1'b0, 1'b0);
    send_frame(14'h0123, 1'b0, 1'b0, 1'b1);
    send_frame(14'h00DE, 1'b0, 1'b0, 1'b0);
    send_frame(14'h00F0, 1'b0, 1'b0, 1'b0);
    for (int k = 0; k < 3; k++) send_frame(14'h0555, 1'b0, 1'b0, 1'b1);
    send_frame(14'h0777, 1'b0, 1'b0, 1'b1);
    send_frame(14'h0, 1'b0, 1'b0, 1'b1);
    send_frame(14'h0, 1'b0, 1'b0, 1'b1);
    chk(gs[b] == 16'h0ABC, "R7 single mismatch still strobes", gs[b], 16'h0ABC);
    chk(gs[b+1] == 16'h0123, "R7 next good frame", gs[b+1], 16'h0123);
    chk(gs[b+2] == 16'h00DE, "R7 first of two mismatches", gs[b+2], 16'h00DE);
    chk(gs[b+3] == 16'h0777, "R8 relock after four frames", gs[b+3], 16'h0777);
    chk(nfall - f0 == 1, "R7 lock dropped once", nfall - f0, 1);

    // Odd bit slip: R8
    f0 = nfall;
    send_bit(1'b0, 1'b0, 1'b0);
    for (int k = 0; k < 10; k++) send_frame(14'h0100 + 14'(k), 1'b0, 1'b0, 1'b1);
    send_frame(14'h2FFF, 1'b0, 1'b0, 1'b1);
    send_frame(14'h2FFF, 1'b0, 1'b0, 1'b1);
    repeat (3) @(negedge bclk);
    #1;
    e = nv;
    chk(gs[e-1] == 16'hEFFF, "R8 R3 slipped negative sample", gs[e-1], 16'hEFFF);
    chk(gs[e-3] == 16'h0109, "R8 slipped sample", gs[e-3], 16'h0109);
    chk(gs[e-4] == 16'h0108, "R8 slipped sample", gs[e-4], 16'h0108);
    chk(nfall - f0 == 1, "R8 one loss before realign", nfall - f0, 1);
    chk(frm_lock == 1, "R8 relocked", frm_lock, 1);

    // Reset while locked: R10
    rst = 1;
    @(negedge bclk); #1;
    chk(frm_lock == 0 && smp_vld == 0 && pad_err == 0, "R10 reset clears", {frm_lock, smp_vld, pad_err}, 0);
    n0 = nv;
    for (int k = 0; k < 5; k++) send_frame(14'h0333, 1'b1, 1'b0, 1'b1);
    @(negedge bclk); #1;
    chk(frm_lock == 0 && nv == n0, "R10 held reset blocks lock", frm_lock, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule